// File: doc/BRIEF.md
# Two-Channel PWM Burst Generator

The block drives two independent pulse-width outputs. Each channel holds a high duration and a low duration, both counted in ticks of a slow time base, and a burst length. While a channel is enabled it drives its output high for the high duration, then low for the low duration, and repeats. With a burst length of zero it repeats without end. With a nonzero burst length it stops after that many complete high/low periods, drives its output low and clears its own enable bit.

All settings arrive as single-cycle command beats on a configuration stream: an 8-bit command code and a 16-bit value. The stream has a valid/ready handshake, but the block never applies back-pressure. `cmd_ready` is high in every cycle after reset, so a beat is taken on any clock edge where `cmd_valid` is high. A free-running prescaler divides the system clock by `TICK_DIV` to make a single-cycle tick. With the default value this tick comes every 100 us at 125 MHz. The present enable state of each channel is visible on `run_mask`.

Top module: `pwm_burst_gen`

## Requirements
- R1: After reset, `pwm_out` and `run_mask` are 0, every stored duration is 1 tick and every burst length is 0.
- R2: The internal tick fires exactly once every `TICK_DIV` clock cycles. An enabled channel with durations of 1 changes its output once per tick.
- R3: An enabled channel is high for its high duration in ticks, then low for its low duration, and repeats. The output is high in the first cycle after the edge that enables it.
- R4: Code 0x10+2x writes the high duration of channel x and code 0x11+2x writes its low duration. A written value of 0 is stored as 1.
- R5: Code 0x14+x writes the burst length of channel x. A burst length of 0 makes the channel run without end.
- R6: With a nonzero burst length N, the channel finishes after N complete periods. On the tick that ends the last low phase, its `run_mask` bit clears and its output goes low.
- R7: Code 0x1f loads `run_mask` from the low bits of the value, where bit x enables channel x. A cleared bit forces the output low in the next cycle. Enabling again starts a fresh high phase, with the period and burst counters cleared.
- R8: A beat carrying any other code changes no duration, burst length or enable bit.
- R9: `cmd_ready` is 1 in every cycle after reset.
- R10: If a 0x1f write lands on the same edge as a burst completion, the written mask wins, and a re-enabled channel restarts from a fresh high phase.
- R11: If a duration is rewritten below the number of ticks already spent in the current phase, that phase ends on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command beat present |
| cmd_ready | output | 1 | Beat accepted (always 1 after reset) |
| cmd_code | input | 8 | Command code |
| cmd_data | input | 16 | Command value |
| pwm_out | output | NUM_CH | Per-channel pulse output |
| run_mask | output | NUM_CH | Per-channel enable state |

## Verification
The hardest case to reach is a 0x1f write that lands on the exact edge where a burst completes. That edge depends on the free-running prescaler phase, on the elapsed count in the last low phase and on the period count. The bench steers its behavioural reference model forward cycle by cycle and watches for the cycle in which the model predicts completion on the coming edge. It then drives the mask write in that very cycle and confirms that the bit stays set and the output restarts high. Shortening a duration in the middle of a phase is reached in a similar way: the bench waits deep into a long high phase before rewriting it.

// File: rtl/pwm_burst_pkg.sv
package pwm_burst_pkg;
  localparam int CODE_W      = 8;
  localparam int DATA_W      = 16;
  localparam int OP_HI_BASE  = 'h10;
  localparam int OP_LO_BASE  = 'h11;
  localparam int OP_CNT_BASE = 'h14;
  localparam int OP_MASK     = 'h1f;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int TICK_DIV = 12500
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] div_cnt;

  assign tick = (div_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else           div_cnt <= div_cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_burst_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [CODE_W-1:0]              wr_code,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [NUM_CH-1:0]              burst_done,
  output logic [NUM_CH-1:0][DATA_W-1:0]  hi_len,
  output logic [NUM_CH-1:0][DATA_W-1:0]  lo_len,
  output logic [NUM_CH-1:0][DATA_W-1:0]  burst_len,
  output logic [NUM_CH-1:0]              en_mask
);
  localparam logic [DATA_W-1:0] ONE_TICK = DATA_W'(1);

  logic [DATA_W-1:0] len_val;
  logic              mask_hit;

  // zero durations are not allowed: store the minimum instead
  assign len_val  = (wr_data == '0) ? ONE_TICK : wr_data;
  assign mask_hit = wr_en && (wr_code == CODE_W'(OP_MASK));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hi_hit, lo_hit, cnt_hit;
    assign hi_hit  = wr_en && (wr_code == CODE_W'(OP_HI_BASE + 2 * i));
    assign lo_hit  = wr_en && (wr_code == CODE_W'(OP_LO_BASE + 2 * i));
    assign cnt_hit = wr_en && (wr_code == CODE_W'(OP_CNT_BASE + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_len[i]    <= ONE_TICK;
        lo_len[i]    <= ONE_TICK;
        burst_len[i] <= '0;
      end else begin
        if (hi_hit)  hi_len[i]    <= len_val;
        if (lo_hit)  lo_len[i]    <= len_val;
        if (cnt_hit) burst_len[i] <= wr_data;
      end
    end
  end

  // an explicit mask write takes precedence over burst completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_mask <= '0;
    else if (mask_hit) en_mask <= wr_data[NUM_CH-1:0];
    else               en_mask <= en_mask & ~burst_done;
  end
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
  import pwm_burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic [DATA_W-1:0] hi_len,
  input  logic [DATA_W-1:0] lo_len,
  input  logic [DATA_W-1:0] burst_len,
  output logic              pwm,
  output logic              done
);
  phase_e            phase;
  logic [DATA_W-1:0] elapsed;
  logic [DATA_W-1:0] periods;
  logic [DATA_W:0]   elapsed_nx;
  logic [DATA_W:0]   periods_nx;
  logic              hi_end, lo_end, last_period;

  assign elapsed_nx  = {1'b0, elapsed} + 1'b1;
  assign periods_nx  = {1'b0, periods} + 1'b1;
  // >= so that a shortened duration or burst ends on the next tick
  assign hi_end      = elapsed_nx >= {1'b0, hi_len};
  assign lo_end      = elapsed_nx >= {1'b0, lo_len};
  assign last_period = (burst_len != '0) && (periods_nx >= {1'b0, burst_len});

  assign done = enable && tick && (phase == PH_LOW) && lo_end && last_period;
  assign pwm  = enable && (phase == PH_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_HIGH;
      elapsed <= '0;
      periods <= '0;
    end else if (!enable) begin
      phase   <= PH_HIGH;
      elapsed <= '0;
      periods <= '0;
    end else if (tick) begin
      if (phase == PH_HIGH) begin
        if (hi_end) begin
          phase   <= PH_LOW;
          elapsed <= '0;
        end else begin
          elapsed <= elapsed_nx[DATA_W-1:0];
        end
      end else if (lo_end) begin
        phase   <= PH_HIGH;
        elapsed <= '0;
        periods <= last_period ? '0 : periods_nx[DATA_W-1:0];
      end else begin
        elapsed <= elapsed_nx[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pwm_burst_gen.sv
module pwm_burst_gen
  import pwm_burst_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int TICK_DIV = 12500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_code,
  input  logic [15:0]       cmd_data,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] run_mask
);
  logic                          tick;
  logic                          take;
  logic [NUM_CH-1:0][DATA_W-1:0] hi_len, lo_len, burst_len;
  logic [NUM_CH-1:0]             en_mask;
  logic [NUM_CH-1:0]             burst_done;

  assign cmd_ready = rst_n;
  assign take      = cmd_valid && cmd_ready;
  assign run_mask  = en_mask;

  pwm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  pwm_cfg_regs #(.NUM_CH(NUM_CH)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (take),
    .wr_code    (cmd_code),
    .wr_data    (cmd_data),
    .burst_done (burst_done),
    .hi_len     (hi_len),
    .lo_len     (lo_len),
    .burst_len  (burst_len),
    .en_mask    (en_mask)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    pwm_chan_core u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (en_mask[i]),
      .tick      (tick),
      .hi_len    (hi_len[i]),
      .lo_len    (lo_len[i]),
      .burst_len (burst_len[i]),
      .pwm       (pwm_out[i]),
      .done      (burst_done[i])
    );
  end
endmodule

// File: rtl/pwm_burst_gen_chk.sv
module pwm_burst_gen_chk
  import pwm_burst_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int TICK_DIV = 12500
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cmd_valid,
  input logic [7:0]                    cmd_code,
  input logic                          tick,
  input logic [NUM_CH-1:0]             pwm_out,
  input logic [NUM_CH-1:0]             run_mask,
  input logic [NUM_CH-1:0][DATA_W-1:0] hi_len,
  input logic [NUM_CH-1:0][DATA_W-1:0] lo_len,
  input logic [NUM_CH-1:0][DATA_W-1:0] burst_len
);
  logic        mask_wr;
  logic [31:0] since_tick;
  logic        seen_tick;

  assign mask_wr = cmd_valid && (cmd_code == 8'(OP_MASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_tick <= '0;
      seen_tick  <= 1'b0;
    end else if (tick) begin
      since_tick <= '0;
      seen_tick  <= 1'b1;
    end else begin
      since_tick <= since_tick + 1'b1;
    end
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen_tick) |-> (since_tick == 32'(TICK_DIV - 1)));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    // R7
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_mask[i] |-> !pwm_out[i]);
    // R7
    enable_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_mask[i]) |-> $past(mask_wr));
    // R6
    finish_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(run_mask[i]) && !$past(mask_wr)) |->
        ($past(tick) && $past(burst_len[i] != '0) && !pwm_out[i]));
    // R3
    edge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_out[i] != $past(pwm_out[i])) |-> ($past(tick) || $past(mask_wr)));
    // R4
    len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_len[i] != '0) && (lo_len[i] != '0));
  end
endmodule

bind pwm_burst_gen pwm_burst_gen_chk #(.NUM_CH(NUM_CH), .TICK_DIV(TICK_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .tick      (tick),
  .pwm_out   (pwm_out),
  .run_mask  (run_mask),
  .hi_len    (hi_len),
  .lo_len    (lo_len),
  .burst_len (burst_len)
);

// File: tb/pwm_burst_gen_tb.sv
module pwm_burst_gen_tb;
  localparam int DIV = 4;
  localparam int NC  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [7:0]    cmd_code = '0;
  logic [15:0]   cmd_data = '0;
  logic [NC-1:0] pwm_out, run_mask;

  always #4 clk = ~clk;

  pwm_burst_gen #(.NUM_CH(NC), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_data(cmd_data), .pwm_out(pwm_out), .run_mask(run_mask)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    cmp_on = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_ph[NC], m_el[NC], m_pe[NC], m_hi[NC], m_lo[NC], m_bu[NC];
  logic [NC-1:0] m_mask, m_done;
  int m_pc;
  bit m_t;

  function automatic bit will_finish(int ch);
    return m_mask[ch] && (m_pc == DIV - 1) && (m_ph[ch] == 0) &&
           (m_el[ch] + 1 >= m_lo[ch]) && (m_bu[ch] != 0) && (m_pe[ch] + 1 >= m_bu[ch]);
  endfunction

  function automatic logic [NC-1:0] model_out();
    logic [NC-1:0] o;
    for (int c = 0; c < NC; c++) o[c] = m_mask[c] && (m_ph[c] == 1);
    return o;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_ph[c] = 1; m_el[c] = 0; m_pe[c] = 0; m_hi[c] = 1; m_lo[c] = 1; m_bu[c] = 0;
      end
      m_mask = '0; m_pc = 0;
    end else begin
      m_t = (m_pc == DIV - 1);
      m_pc = m_t ? 0 : m_pc + 1;
      m_done = '0;
      for (int c = 0; c < NC; c++) begin
        if (!m_mask[c]) begin
          m_ph[c] = 1; m_el[c] = 0; m_pe[c] = 0;
        end else if (m_t) begin
          if (m_ph[c] == 1) begin
            if (m_el[c] + 1 >= m_hi[c]) begin m_ph[c] = 0; m_el[c] = 0; end
            else m_el[c]++;
          end else if (m_el[c] + 1 >= m_lo[c]) begin
            m_ph[c] = 1; m_el[c] = 0;
            if (m_bu[c] != 0 && m_pe[c] + 1 >= m_bu[c]) begin m_done[c] = 1'b1; m_pe[c] = 0; end
            else m_pe[c]++;
          end else m_el[c]++;
        end
      end
      if (cmd_valid) begin
        for (int c = 0; c < NC; c++) begin
          if (cmd_code == 8'(16 + 2 * c)) m_hi[c] = (cmd_data == 0) ? 1 : int'(cmd_data);
          if (cmd_code == 8'(17 + 2 * c)) m_lo[c] = (cmd_data == 0) ? 1 : int'(cmd_data);
          if (cmd_code == 8'(20 + c))     m_bu[c] = int'(cmd_data);
        end
      end
      if (cmd_valid && cmd_code == 8'h1f) m_mask = cmd_data[NC-1:0];
      else                                m_mask = m_mask & ~m_done;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(cur_req, int'(pwm_out), int'(model_out()));
      chk(cur_req, int'(run_mask), int'(m_mask));
      chk("R9", int'(cmd_ready), 1);
    end
  end

  task automatic send_now(logic [7:0] code, logic [15:0] data);
    cmd_valid = 1'b1; cmd_code = code; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = '0; cmd_data = '0;
  endtask

  task automatic send(logic [7:0] code, logic [15:0] data);
    @(negedge clk);
    send_now(code, data);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    logic prev;
    bit found;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", int'(pwm_out), 0);
    chk("R1", int'(run_mask), 0);
    rst_n = 1'b1;
    cmp_on = 1;

    // R2: default durations of 1 toggle once per tick
    cur_req = "R2";
    send(8'h1f, 16'h0001);
    @(negedge clk);
    cnt = 0; prev = pwm_out[0];
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwm_out[0] != prev) cnt++;
      prev = pwm_out[0];
    end
    chk("R2", cnt, 10);

    // R3: high 3 ticks, low 2 ticks -> 60 high cycles in 100
    cur_req = "R3";
    send(8'h1f, 16'h0000);
    send(8'h10, 16'd3);
    send(8'h11, 16'd2);
    send(8'h1f, 16'h0001);
    chk("R3", int'(pwm_out[0]), 1);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      if (pwm_out[0]) cnt++;
      @(negedge clk);
    end
    chk("R3", cnt, 60);

    // R8: other codes ignored
    cur_req = "R8";
    send(8'h16, 16'h0007);
    send(8'h00, 16'h0000);
    send(8'h1e, 16'h0003);
    send(8'h0f, 16'h0005);
    repeat (30) @(negedge clk);
    chk("R8", int'(run_mask), 1);

    // R4: zero duration stored as one tick
    cur_req = "R4";
    send(8'h11, 16'h0000);
    repeat (30) @(negedge clk);

    // R5 / R6: channel 1 burst of 3, channel 0 continuous
    cur_req = "R6";
    send(8'h14, 16'h0000);
    send(8'h15, 16'd3);
    send(8'h12, 16'd2);
    send(8'h13, 16'd1);
    send(8'h1f, 16'h0003);
    repeat (50) @(negedge clk);
    chk("R6", int'(run_mask[1]), 0);
    chk("R6", int'(pwm_out[1]), 0);
    chk("R5", int'(run_mask[0]), 1);

    // R7: disable forces low, re-enable restarts a fresh high phase
    cur_req = "R7";
    send(8'h10, 16'd20);
    cnt = 0;
    while (!pwm_out[0] && cnt < 200) begin @(negedge clk); cnt++; end
    send_now(8'h1f, 16'h0000);
    chk("R7", int'(pwm_out[0]), 0);
    send(8'h1f, 16'h0001);
    chk("R7", int'(pwm_out[0]), 1);
    repeat (60) @(negedge clk);
    chk("R7", int'(pwm_out[0]), 1);

    // R11: shorten the high duration deep into the phase
    cur_req = "R11";
    send_now(8'h10, 16'd2);
    repeat (DIV + 1) @(negedge clk);
    chk("R11", int'(pwm_out[0]), 0);

    // R10: mask write on the completion edge
    cur_req = "R10";
    send(8'h10, 16'd1);
    send(8'h11, 16'd1);
    send(8'h14, 16'd1);
    found = 0;
    for (int i = 0; i < 200 && !found; i++) begin
      @(negedge clk);
      if (will_finish(0)) found = 1;
    end
    chk("R10", int'(found), 1);
    send_now(8'h1f, 16'h0001);
    chk("R10", int'(run_mask[0]), 1);
    chk("R10", int'(pwm_out[0]), 1);

    send(8'h1f, 16'h0000);
    repeat (5) @(negedge clk);
    cmp_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule